// File: doc/BRIEF.md
# Memory Caching Type Resolver

This unit answers one question for a physical address: which caching policy applies to it. It draws on three sources. The first is a table of fixed-granule entries that covers the first megabyte. The second is a set of programmable variable ranges, each described by a base and a mask. The third is a default type held in a control word. A requester pulses a strobe together with an address, and the resolved type code is presented, registered, on the following cycle.

Below 1 MiB the fixed table uses three granule sizes. The lowest 512 KiB is divided into 64 KiB granules. The next 256 KiB is divided into 16 KiB granules. The final 256 KiB is divided into 4 KiB granules. Above that point, or when the fixed table is switched off, the address is compared against every enabled variable range. When several variable ranges hit the same address, their types are combined by a precedence rule that favours the safer policy. When no range hits, the default type is used. If both enables are off, lookups are disabled and a reserved code is returned.

The unit holds no configuration of its own. The control word, the fixed table and the range pairs are inputs, and the owning logic keeps them stable.

Top module: `mem_type_resolver`

## Requirements
- R1: When `req_i` is high at a rising edge, `rsp_valid_o` is high in the following cycle, and `rsp_type_o` shows the result for the address and configuration sampled at that edge. When `req_i` is low at an edge, `rsp_valid_o` is low in the next cycle and `rsp_type_o` keeps its value. After reset, `rsp_valid_o` is 0 and `rsp_type_o` is 8'hFF.
- R2: When control bits 11 and 10 are both 0, the result is the reserved code 8'hFF, whatever the address or the other inputs.
- R3: When control bit 10 (fixed enable) is set and the address is below 0x80000, the result is fixed entry address[18:16]. Fixed entry k occupies `fixed_types_i[8k+7:8k]`.
- R4: When fixed enable is set and the address is in 0x80000..0xBFFFF, the result is fixed entry 8 + ((address-0x80000)>>14), which covers entries 8 to 23.
- R5: When fixed enable is set and the address is in 0xC0000..0xFFFFF, the result is fixed entry 24 + ((address-0xC0000)>>12), which covers entries 24 to 87.
- R6: The fixed table is not consulted when bit 10 is clear or when the address is 0x100000 or higher. In those cases the variable-range path or the default type decides.
- R7: When control bit 11 (variable enable) is clear, any address not served by the fixed table returns the default type held in control bits 7:0. Variable ranges have no effect in this case.
- R8: Variable range i takes part only if bit 11 of its mask word is set. It hits when (address & mask) equals (base & mask) over bits 35:12. Bits 11:0 of the address, the base and the mask never take part in the comparison.
- R9: When exactly one range hits, the result is that range's type, held in bits 7:0 of its base word. Type codes are UC=0, WC=1, WT=4, WP=5 and WB=6.
- R10: When several ranges hit and any of them is UC (0), the result is UC.
- R11: When the hitting ranges are only WB (6) and WT (4), in any order and any number, the result is WT.
- R12: When the hitting ranges all carry the same type, the result is that type. Any other mix of types resolves to UC.
- R13: When variable enable is set and no range hits, the result is the default type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Lookup strobe |
| addr_i | input | 36 | Physical address to classify |
| ctrl_i | input | 12 | Bit 11 variable enable, bit 10 fixed enable, bits 7:0 default type |
| fixed_types_i | input | 704 | 88 fixed entries of 8 bits each; entry k at bits 8k+7:8k |
| var_base_i | input | 288 | 8 base words of 36 bits; bits 35:12 address, bits 7:0 type |
| var_mask_i | input | 288 | 8 mask words of 36 bits; bits 35:12 mask, bit 11 range enable |
| rsp_valid_o | output | 1 | High one cycle after a strobe |
| rsp_type_o | output | 8 | Resolved type code, held between strobes |

## Verification
The only state in the unit is its output register, so any fault in the resolution logic appears at `rsp_type_o` in the single cycle after the strobe that exposes it. A wrong merge accumulator can only show when two or more ranges hit the same address, so the bench builds overlapping pairs and a triple. These cover the UC override, the WB/WT pairing in both index orders and mixed types. A wrong fixed-table index shows as a neighbouring entry's code. For that reason every granule region is probed at its first and last granule and at one interior point. A fault in the hold path shows as `rsp_type_o` changing on a cycle with no strobe.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int TYPE_W     = 8;
    localparam int CTRL_W     = 12;
    localparam int CTL_FIX_EN = 10;
    localparam int CTL_VAR_EN = 11;
    localparam int MASK_VLD   = 11;
    localparam int PAGE_LSB   = 12;
    localparam int FIX_NUM    = 88;
    localparam int FIX_IDX_W  = $clog2(FIX_NUM);
    localparam int LOW_MEM_LSB = 20;

    typedef logic [TYPE_W-1:0] mem_type_t;

    localparam mem_type_t MT_UC   = 8'h00;
    localparam mem_type_t MT_WC   = 8'h01;
    localparam mem_type_t MT_WT   = 8'h04;
    localparam mem_type_t MT_WP   = 8'h05;
    localparam mem_type_t MT_WB   = 8'h06;
    localparam mem_type_t MT_NONE = 8'hFF;

    typedef struct packed {
        logic      var_en;
        logic      fix_en;
        mem_type_t dflt;
    } lookup_ctrl_t;

    typedef struct packed {
        logic      seen;
        mem_type_t ty;
    } merge_acc_t;

    function automatic lookup_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] c);
        lookup_ctrl_t r;
        r.var_en = c[CTL_VAR_EN];
        r.fix_en = c[CTL_FIX_EN];
        r.dflt   = c[TYPE_W-1:0];
        return r;
    endfunction

    // Precedence between two overlapping hits.
    function automatic mem_type_t merge_pair(input mem_type_t a, input mem_type_t b);
        if (a == MT_UC || b == MT_UC)
            return MT_UC;
        if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB))
            return MT_WT;
        if (a == b)
            return a;
        return MT_UC;
    endfunction

    // Entry number inside the sub-megabyte table, from the low 20 address bits.
    function automatic logic [FIX_IDX_W-1:0] fix_index(input logic [19:0] a);
        logic [FIX_IDX_W-1:0] idx;
        if (!a[19])
            idx = FIX_IDX_W'(a[18:16]);
        else if (!a[18])
            idx = FIX_IDX_W'(8) + FIX_IDX_W'(a[17:14]);
        else
            idx = FIX_IDX_W'(24) + FIX_IDX_W'(a[17:12]);
        return idx;
    endfunction

endpackage

// File: rtl/mtr_fixed_sel.sv
module mtr_fixed_sel
    import mtr_pkg::*;
(
    input  logic [19:0]              addr_lo_i,
    input  logic [FIX_NUM*TYPE_W-1:0] table_i,
    output mem_type_t                type_o
);
    logic [FIX_IDX_W-1:0] idx;

    always_comb begin
        idx    = fix_index(addr_lo_i);
        type_o = table_i[int'(idx)*TYPE_W +: TYPE_W];
    end
endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [NUM_VAR*ADDR_W-1:0]      base_i,
    input  logic [NUM_VAR*ADDR_W-1:0]      mask_i,
    output logic [NUM_VAR-1:0]             hit_o,
    output logic [NUM_VAR-1:0][TYPE_W-1:0] type_o
);
    localparam int CMP_W = ADDR_W - PAGE_LSB;

    for (genvar g = 0; g < NUM_VAR; g++) begin : g_rng
        logic [ADDR_W-1:0] base_w;
        logic [ADDR_W-1:0] mask_w;
        logic [CMP_W-1:0]  cmp_mask;

        assign base_w    = base_i[g*ADDR_W +: ADDR_W];
        assign mask_w    = mask_i[g*ADDR_W +: ADDR_W];
        assign cmp_mask  = mask_w[ADDR_W-1:PAGE_LSB];
        assign hit_o[g]  = mask_w[MASK_VLD] &&
                           ((addr_i[ADDR_W-1:PAGE_LSB] & cmp_mask) ==
                            (base_w[ADDR_W-1:PAGE_LSB] & cmp_mask));
        assign type_o[g] = base_w[TYPE_W-1:0];
    end
endmodule

// File: rtl/mtr_merge.sv
module mtr_merge
    import mtr_pkg::*;
#(
    parameter int NUM_VAR = 8
) (
    input  logic [NUM_VAR-1:0]             hit_i,
    input  logic [NUM_VAR-1:0][TYPE_W-1:0] type_i,
    output logic                           any_o,
    output mem_type_t                      type_o
);
    merge_acc_t acc;

    always_comb begin
        acc = '{seen: 1'b0, ty: MT_UC};
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit_i[i]) begin
                if (!acc.seen)
                    acc = '{seen: 1'b1, ty: type_i[i]};
                else
                    acc = '{seen: 1'b1, ty: merge_pair(acc.ty, type_i[i])};
            end
        end
        any_o  = acc.seen;
        type_o = acc.ty;
    end
endmodule

// File: rtl/mem_type_resolver.sv
module mem_type_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [CTRL_W-1:0]             ctrl_i,
    input  logic [FIX_NUM*TYPE_W-1:0]     fixed_types_i,
    input  logic [NUM_VAR*ADDR_W-1:0]     var_base_i,
    input  logic [NUM_VAR*ADDR_W-1:0]     var_mask_i,
    output logic                          rsp_valid_o,
    output logic [TYPE_W-1:0]             rsp_type_o
);
    localparam int HI_W = ADDR_W - LOW_MEM_LSB;

    lookup_ctrl_t                   ctl;
    mem_type_t                      fix_type;
    logic [NUM_VAR-1:0]             hits;
    logic [NUM_VAR-1:0][TYPE_W-1:0] hit_types;
    logic                           any_hit;
    mem_type_t                      var_type;
    mem_type_t                      resolved;
    logic                           in_low_mb;

    assign ctl       = decode_ctrl(ctrl_i);
    assign in_low_mb = (addr_i[ADDR_W-1:LOW_MEM_LSB] == HI_W'(0));

    mtr_fixed_sel u_fixed (
        .addr_lo_i (addr_i[LOW_MEM_LSB-1:0]),
        .table_i   (fixed_types_i),
        .type_o    (fix_type)
    );

    mtr_var_match #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_match (
        .addr_i (addr_i),
        .base_i (var_base_i),
        .mask_i (var_mask_i),
        .hit_o  (hits),
        .type_o (hit_types)
    );

    mtr_merge #(.NUM_VAR(NUM_VAR)) u_merge (
        .hit_i  (hits),
        .type_i (hit_types),
        .any_o  (any_hit),
        .type_o (var_type)
    );

    always_comb begin
        if (!ctl.var_en && !ctl.fix_en)
            resolved = MT_NONE;
        else if (ctl.fix_en && in_low_mb)
            resolved = fix_type;
        else if (!ctl.var_en)
            resolved = ctl.dflt;
        else if (any_hit)
            resolved = var_type;
        else
            resolved = ctl.dflt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_type_o  <= MT_NONE;
        end else begin
            rsp_valid_o <= req_i;
            if (req_i)
                rsp_type_o <= resolved;
        end
    end
endmodule

// File: rtl/mem_type_resolver_chk.sv
module mem_type_resolver_chk
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_i,
    input logic [ADDR_W-1:0]         addr_i,
    input logic [CTRL_W-1:0]         ctrl_i,
    input logic [NUM_VAR*ADDR_W-1:0] var_mask_i,
    input logic                      rsp_valid_o,
    input logic [TYPE_W-1:0]         rsp_type_o
);
    logic any_enabled;
    logic above_mb;

    always_comb begin
        any_enabled = 1'b0;
        for (int i = 0; i < NUM_VAR; i++)
            any_enabled = any_enabled | var_mask_i[i*ADDR_W + MASK_VLD];
    end
    assign above_mb = |addr_i[ADDR_W-1:LOW_MEM_LSB];

    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_valid_o);

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!rsp_valid_o && $stable(rsp_type_o)));

    a_r2_disabled_code: assert property (@(posedge clk) disable iff (rst)
        (req_i && ctrl_i[CTL_VAR_EN] == 1'b0 && ctrl_i[CTL_FIX_EN] == 1'b0)
        |=> rsp_type_o == MT_NONE);

    a_r7_var_off_default: assert property (@(posedge clk) disable iff (rst)
        (req_i && !ctrl_i[CTL_VAR_EN] && ctrl_i[CTL_FIX_EN] && above_mb)
        |=> rsp_type_o == $past(ctrl_i[TYPE_W-1:0]));

    a_r13_no_range_default: assert property (@(posedge clk) disable iff (rst)
        (req_i && ctrl_i[CTL_VAR_EN] && !ctrl_i[CTL_FIX_EN] && !any_enabled)
        |=> rsp_type_o == $past(ctrl_i[TYPE_W-1:0]));
endmodule

bind mem_type_resolver mem_type_resolver_chk #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .ctrl_i      (ctrl_i),
    .var_mask_i  (var_mask_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_type_o  (rsp_type_o)
);

// File: tb/mem_type_resolver_tb.sv
module mem_type_resolver_tb;
    localparam int CLK_P   = 10;
    localparam int ADDR_W  = 36;
    localparam int NUM_VAR = 8;
    localparam int NFIX    = 88;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req = 1'b0;
    logic [ADDR_W-1:0]         addr = '0;
    logic [11:0]               ctrl = '0;
    logic [NFIX*8-1:0]         fixed_types;
    logic [NUM_VAR*ADDR_W-1:0] bases = '0;
    logic [NUM_VAR*ADDR_W-1:0] masks = '0;
    logic                      rsp_valid;
    logic [7:0]                rsp_type;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mem_type_resolver #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req),
        .addr_i        (addr),
        .ctrl_i        (ctrl),
        .fixed_types_i (fixed_types),
        .var_base_i    (bases),
        .var_mask_i    (masks),
        .rsp_valid_o   (rsp_valid),
        .rsp_type_o    (rsp_type)
    );

    function automatic logic [7:0] fx(input int k);
        return 8'((k * 37 + 11) % 256);
    endfunction

    function automatic logic [11:0] mk_ctrl(input bit v, input bit f, input logic [7:0] d);
        return {v, f, 2'b00, d};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_vars();
        bases = '0;
        masks = '0;
    endtask

    task automatic set_var(input int i, input logic [35:0] b, input logic [35:0] m,
                           input logic [7:0] ty, input bit en);
        bases[i*ADDR_W +: ADDR_W] = {b[35:12], 4'h0, ty};
        masks[i*ADDR_W +: ADDR_W] = {m[35:12], en, 11'h000};
    endtask

    task automatic lookup(input logic [35:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req  = 1'b0;
        check("R1 valid", {7'b0, rsp_valid}, 8'h01);
        check(tag, rsp_type, exp);
    endtask

    task automatic t_reset();
        check("R1 reset valid", {7'b0, rsp_valid}, 8'h00);
        check("R1 reset type", rsp_type, 8'hFF);
    endtask

    task automatic t_disabled();
        clear_vars();
        set_var(0, 36'h0_0000_0000, 36'h0_0000_0000, 8'h06, 1'b1);
        ctrl = mk_ctrl(1'b0, 1'b0, 8'h06);
        lookup(36'h0_0003_0000, 8'hFF, "R2 low");
        lookup(36'h3_1234_5000, 8'hFF, "R2 high");
    endtask

    task automatic t_fixed();
        clear_vars();
        ctrl = mk_ctrl(1'b1, 1'b1, 8'h05);
        lookup(36'h0_0000_0000, fx(0), "R3 first");
        lookup(36'h0_0003_1234, fx(3), "R3 mid");
        lookup(36'h0_0007_FFFF, fx(7), "R3 last");
        lookup(36'h0_0008_0000, fx(8), "R4 first");
        lookup(36'h0_000A_4000, fx(8 + (32'h24000 >> 14)), "R4 mid");
        lookup(36'h0_000B_FFFF, fx(23), "R4 last");
        lookup(36'h0_000C_0000, fx(24), "R5 first");
        lookup(36'h0_000D_3ABC, fx(24 + (32'h13ABC >> 12)), "R5 mid");
        lookup(36'h0_000F_FFFF, fx(87), "R5 last");
    endtask

    task automatic t_fixed_bypass();
        clear_vars();
        ctrl = mk_ctrl(1'b1, 1'b0, 8'h06);
        lookup(36'h0_0003_0000, 8'h06, "R6 fixed off default");
        set_var(1, 36'h0_0000_0000, 36'hF_FFF0_0000, 8'h01, 1'b1);
        lookup(36'h0_0003_0000, 8'h01, "R6 fixed off range");
        clear_vars();
        ctrl = mk_ctrl(1'b1, 1'b1, 8'h04);
        lookup(36'h1_0003_0000, 8'h04, "R6 above 1MiB");
    endtask

    task automatic t_var_off();
        clear_vars();
        set_var(2, 36'h1_0000_0000, 36'hF_0000_0000, 8'h01, 1'b1);
        ctrl = mk_ctrl(1'b0, 1'b1, 8'h05);
        lookup(36'h1_0000_0000, 8'h05, "R7 var off");
        lookup(36'h0_0004_0000, fx(4), "R7 fixed still used");
    endtask

    task automatic t_single();
        clear_vars();
        ctrl = mk_ctrl(1'b1, 1'b1, 8'h00);
        set_var(4, 36'h2_0000_0000, 36'hF_F000_0000, 8'h01, 1'b1);
        lookup(36'h2_0ABC_D123, 8'h01, "R9 single WC");
        lookup(36'h2_1000_0000, 8'h00, "R13 outside range");
        set_var(4, 36'h2_0000_0000, 36'hF_F000_0000, 8'h01, 1'b0);
        lookup(36'h2_0ABC_D123, 8'h00, "R8 disabled range");
        set_var(6, 36'h2_0000_0000, 36'hF_FFFF_F000, 8'h05, 1'b1);
        lookup(36'h2_0000_0FFF, 8'h05, "R8 page offset ignored");
        lookup(36'h2_0000_1000, 8'h00, "R8 next page");
    endtask

    task automatic t_overlap();
        ctrl = mk_ctrl(1'b1, 1'b1, 8'h01);
        clear_vars();
        set_var(0, 36'h1_0000_0000, 36'hF_0000_0000, 8'h06, 1'b1);
        set_var(3, 36'h1_4000_0000, 36'hF_C000_0000, 8'h04, 1'b1);
        lookup(36'h1_4000_1000, 8'h04, "R11 WB then WT");
        lookup(36'h1_0000_5000, 8'h06, "R9 only WB");
        set_var(6, 36'h1_4000_0000, 36'hF_C000_0000, 8'h06, 1'b1);
        lookup(36'h1_4000_1000, 8'h04, "R11 WB WT WB");
        clear_vars();
        set_var(0, 36'h1_0000_0000, 36'hF_0000_0000, 8'h04, 1'b1);
        set_var(5, 36'h1_4000_0000, 36'hF_C000_0000, 8'h06, 1'b1);
        lookup(36'h1_4000_1000, 8'h04, "R11 WT then WB");
        clear_vars();
        set_var(0, 36'h1_0000_0000, 36'hF_0000_0000, 8'h06, 1'b1);
        set_var(2, 36'h1_4000_0000, 36'hF_C000_0000, 8'h00, 1'b1);
        set_var(7, 36'h1_4000_0000, 36'hF_C000_0000, 8'h06, 1'b1);
        lookup(36'h1_4000_1000, 8'h00, "R10 UC wins");
        clear_vars();
        set_var(1, 36'h1_0000_0000, 36'hF_0000_0000, 8'h01, 1'b1);
        set_var(2, 36'h1_4000_0000, 36'hF_C000_0000, 8'h06, 1'b1);
        lookup(36'h1_4000_1000, 8'h00, "R12 WC WB mismatch");
        clear_vars();
        set_var(1, 36'h1_0000_0000, 36'hF_0000_0000, 8'h05, 1'b1);
        set_var(2, 36'h1_4000_0000, 36'hF_C000_0000, 8'h05, 1'b1);
        lookup(36'h1_4000_1000, 8'h05, "R12 equal types");
        lookup(36'h3_0000_0000, 8'h01, "R13 no hit default");
    endtask

    task automatic t_hold();
        clear_vars();
        ctrl = mk_ctrl(1'b1, 1'b1, 8'h06);
        lookup(36'h0_0001_0000, fx(1), "R1 setup");
        ctrl = '0;
        addr = 36'h0_000F_0000;
        @(negedge clk);
        check("R1 no strobe valid", {7'b0, rsp_valid}, 8'h00);
        check("R1 no strobe hold", rsp_type, fx(1));
        @(negedge clk);
        check("R1 still held", rsp_type, fx(1));
    endtask

    initial begin
        for (int k = 0; k < NFIX; k++)
            fixed_types[k*8 +: 8] = fx(k);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fixed();
        t_fixed_bypass();
        t_var_off();
        t_single();
        t_overlap();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule